// File: doc/BRIEF.md
# Three-Wire Serial Register Loader with Shadowed RF Update

This block takes control words from a three-wire serial bus (bit clock, data and an active-low enable). It turns them into the configuration fields of a two-channel frequency synthesizer: a radio-frequency (RF) channel and an intermediate-frequency (IF) channel. The bus pins are asynchronous to the system clock. They pass through a synchronizer, and the block works from the edges it sees on the synchronized copies. Each word carries a three-bit address in its last-shifted bits. The address names the channel and one of four formats: short control, long control, divider counters (N and A), and reference counter (R). The length of the word must match the format the address names.

The RF channel has a synchronous update mode. In this mode, new counter values wait in shadow registers and move to the working outputs on a strobe from the divider (`rf_reload`). The low control bits, which carry the charge-pump current, move one strobe later still. The IF channel holds two counter banks, and a control bit picks which one drives its outputs, so the channel can switch between two frequency plans with a single write.

Top module: `syn_serial_ctl`

## Requirements
- R1: After reset every output field reads zero, the RF channel is in direct (non-shadowed) mode and IF bank 0 is selected.
- R2: Data bits are taken on rising edges of `bus_sclk` only while `bus_en_n` is low. Clock and data activity while `bus_en_n` is high changes no output.
- R3: A word takes effect when `bus_en_n` rises. Word bit 0 selects the channel (0 = RF, 1 = IF). Bits 2:1 select the format: 00 short control, 01 long control, 10 N/A counters, 11 R counter. Control bit ck lies at word bit k+3. A short word carries c0..c3 and a long word carries c0..c13.
- R4: Words are sent most significant bit first. The N and R values lie in word bits 16:3. A lies in bits 22:17 for RF and bits 20:17 for IF.
- R5: A word is accepted only when its length is 7 bits (short), 17 bits (long or R), 23 bits (RF N/A) or 21 bits (IF N/A). A word of any other length is dropped without effect.
- R6: While RF control bit c13 is 1, RF R and N/A words load shadow registers only. An N/A word arms a transfer, and the next `rf_reload` pulse copies the shadowed R, N and A to the outputs. The mode used for a word is the c13 value held before that word. With c13 at 0, the words update the outputs directly.
- R7: IF control bit c3 selects one of two IF N/A banks. IF N/A words write the selected bank, and the IF N/A outputs show the selected bank. An IF short word updates only c0..c2.
- R8: In RF shadowed mode, c0..c3 from short or long words are held back. They reach `rf_ctl` on the first `rf_reload` pulse after the pulse that moved the counters, never earlier. A pulse with no transfer armed changes nothing.
- R9: RF long-word bits c4..c13 update `rf_ctl` directly in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sclk | input | 1 | Serial bit clock (asynchronous) |
| bus_sdat | input | 1 | Serial data (asynchronous) |
| bus_en_n | input | 1 | Active-low word enable (asynchronous) |
| rf_reload | input | 1 | One-cycle strobe from the RF divider reload |
| rf_ctl | output | 14 | RF control bits c0..c13 |
| rf_n | output | 14 | RF N counter value |
| rf_a | output | 6 | RF A counter value |
| rf_r | output | 14 | RF reference counter value |
| if_ctl | output | 14 | IF control bits c0..c13 (c3 = bank select) |
| if_n | output | 14 | IF N value of the selected bank |
| if_a | output | 4 | IF A value of the selected bank |
| if_r | output | 14 | IF reference counter value |

## Verification
On every cycle, the assertions check that the shift state holds still while enable is high and that a commit pulse lasts one cycle. They also check that no RF counter or low control field moves without a write in direct mode or the right reload strobe, that the RF upper control bits move only on long words, and that the IF banks and R value move only on their own words. Other behaviour needs the bench's scenarios: the two-strobe ordering of the shadowed transfer, the choice of mode from the c13 held before each word, dropping words of the wrong length, and switching IF banks through c3. Each of these is a sequence of words and strobes, followed by a read of the output fields.

// File: rtl/syn_ctl_pkg.sv
package syn_ctl_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    FMT_SHORT = 2'b00,
    FMT_LONG  = 2'b01,
    FMT_AN    = 2'b10,
    FMT_REF   = 2'b11
  } fmt_e;
endpackage

// File: rtl/syn_bus_rx.sv
module syn_bus_rx
  import syn_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LO_W        = 4,
  parameter int CTL_W       = 14,
  parameter int CNT_W       = 14,
  parameter int RF_A_W      = 6,
  parameter int IF_A_W      = 4,
  localparam int PAY_W      = CNT_W + RF_A_W,
  localparam int WORD_W     = PAY_W + ADDR_W,
  localparam int CNT_BITS   = $clog2(WORD_W + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             sdat_i,
  input  logic             en_n_i,
  output logic             wr_vld,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PAY_W-1:0] wr_pay
);
  localparam logic [CNT_BITS-1:0] LEN_SHORT = CNT_BITS'(LO_W + ADDR_W);
  localparam logic [CNT_BITS-1:0] LEN_LONG  = CNT_BITS'(CTL_W + ADDR_W);
  localparam logic [CNT_BITS-1:0] LEN_REF   = CNT_BITS'(CNT_W + ADDR_W);
  localparam logic [CNT_BITS-1:0] LEN_AN_RF = CNT_BITS'(CNT_W + RF_A_W + ADDR_W);
  localparam logic [CNT_BITS-1:0] LEN_AN_IF = CNT_BITS'(CNT_W + IF_A_W + ADDR_W);

  // pin vector: [2]=enable_n, [1]=data, [0]=bit clock
  logic [2:0] pin_raw;
  logic [2:0] stg [SYNC_STAGES];
  logic [2:0] pin_s, pin_d;

  assign pin_raw = {en_n_i, sdat_i, sclk_i};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= 3'b100;
      else if (g == 0) stg[g] <= pin_raw;
      else stg[g] <= stg[(g == 0) ? 0 : g - 1];
    end
  end

  assign pin_s = stg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 3'b100;
    else     pin_d <= pin_s;
  end

  logic sclk_rise, en_fall, en_rise;
  assign sclk_rise = pin_s[0] & ~pin_d[0] & ~pin_s[2];
  assign en_fall   = ~pin_s[2] & pin_d[2];
  assign en_rise   = pin_s[2] & ~pin_d[2];

  logic [WORD_W-1:0]   sreg;
  logic [CNT_BITS-1:0] bit_cnt;
  logic [CNT_BITS-1:0] need_len;

  // expected word length for the address now in the low bits
  always_comb begin
    unique case (fmt_e'(sreg[2:1]))
      FMT_SHORT: need_len = LEN_SHORT;
      FMT_LONG:  need_len = LEN_LONG;
      FMT_AN:    need_len = sreg[0] ? LEN_AN_IF : LEN_AN_RF;
      default:   need_len = LEN_REF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      bit_cnt <= '0;
    end else if (en_fall) begin
      sreg    <= '0;
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      sreg <= {sreg[WORD_W-2:0], pin_s[1]};
      if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_vld  <= 1'b0;
      wr_addr <= '0;
      wr_pay  <= '0;
    end else begin
      wr_vld <= en_rise && (bit_cnt == need_len);
      if (en_rise) begin
        wr_addr <= sreg[ADDR_W-1:0];
        wr_pay  <= sreg[WORD_W-1:ADDR_W];
      end
    end
  end

  // R2: with enable high on both sampled copies nothing is shifted in
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (pin_s[2] && pin_d[2]) |=> ($stable(bit_cnt) && $stable(sreg)));

  // R3: a commit is a single-cycle pulse per enable rise
  a_r3_single_commit: assert property (@(posedge clk) disable iff (rst)
    wr_vld |=> !wr_vld);
endmodule

// File: rtl/syn_rf_regs.sv
module syn_rf_regs
  import syn_ctl_pkg::*;
#(
  parameter int CTL_W    = 14,
  parameter int LO_W     = 4,
  parameter int CNT_W    = 14,
  parameter int A_W      = 6,
  parameter int SYNC_BIT = 13,
  localparam int PAY_W   = CNT_W + A_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_vld,
  input  logic [1:0]       wr_fmt,
  input  logic [PAY_W-1:0] wr_pay,
  input  logic             reload,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CNT_W-1:0] n_q,
  output logic [A_W-1:0]   a_q,
  output logic [CNT_W-1:0] r_q
);
  logic [CTL_W-1:0] pay_c;
  logic [CNT_W-1:0] pay_n;
  logic [A_W-1:0]   pay_a;
  assign pay_c = wr_pay[CTL_W-1:0];
  assign pay_n = wr_pay[CNT_W-1:0];
  assign pay_a = wr_pay[PAY_W-1:CNT_W];

  logic [CNT_W-1:0] sh_n, sh_r;
  logic [A_W-1:0]   sh_a;
  logic [LO_W-1:0]  sh_lo;
  logic             cnt_pend, lo_dirty, lo_stage;
  logic             sync_on;

  assign sync_on = ctl_q[SYNC_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      n_q      <= '0;
      a_q      <= '0;
      r_q      <= '0;
      sh_n     <= '0;
      sh_a     <= '0;
      sh_r     <= '0;
      sh_lo    <= '0;
      cnt_pend <= 1'b0;
      lo_dirty <= 1'b0;
      lo_stage <= 1'b0;
    end else begin
      if (reload) begin
        if (lo_stage) begin
          ctl_q[LO_W-1:0] <= sh_lo;
          lo_stage        <= 1'b0;
        end
        if (cnt_pend) begin
          n_q      <= sh_n;
          a_q      <= sh_a;
          r_q      <= sh_r;
          cnt_pend <= 1'b0;
          if (lo_dirty) begin
            lo_stage <= 1'b1;
            lo_dirty <= 1'b0;
          end
        end
      end
      if (wr_vld) begin
        unique case (fmt_e'(wr_fmt))
          FMT_SHORT, FMT_LONG: begin
            if (fmt_e'(wr_fmt) == FMT_LONG)
              ctl_q[CTL_W-1:LO_W] <= pay_c[CTL_W-1:LO_W];
            sh_lo <= pay_c[LO_W-1:0];
            if (sync_on) lo_dirty <= 1'b1;
            else         ctl_q[LO_W-1:0] <= pay_c[LO_W-1:0];
          end
          FMT_AN: begin
            sh_n <= pay_n;
            sh_a <= pay_a;
            if (sync_on) cnt_pend <= 1'b1;
            else begin
              n_q <= pay_n;
              a_q <= pay_a;
            end
          end
          default: begin
            sh_r <= pay_n;
            if (!sync_on) r_q <= pay_n;
          end
        endcase
      end
    end
  end

  // R6: counters move only on a direct write or on a reload strobe
  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!reload && (!wr_vld || sync_on)) |=> $stable({n_q, a_q, r_q}));

  // R8: shadowed low control bits wait for the staged strobe
  a_r8_lo_hold: assert property (@(posedge clk) disable iff (rst)
    (!(reload && lo_stage) && (!wr_vld || sync_on)) |=> $stable(ctl_q[LO_W-1:0]));

  // R9: upper control bits change only through a long word
  a_r9_upper_by_long: assert property (@(posedge clk) disable iff (rst)
    !(wr_vld && wr_fmt == FMT_LONG) |=> $stable(ctl_q[CTL_W-1:LO_W]));
endmodule

// File: rtl/syn_if_regs.sv
module syn_if_regs
  import syn_ctl_pkg::*;
#(
  parameter int CTL_W   = 14,
  parameter int LO_W    = 4,
  parameter int CNT_W   = 14,
  parameter int A_W     = 4,
  parameter int SEL_BIT = 3,
  parameter int BANKS   = 2,
  localparam int PAY_W  = CNT_W + A_W,
  localparam int BSEL_W = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_vld,
  input  logic [1:0]       wr_fmt,
  input  logic [PAY_W-1:0] wr_pay,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CNT_W-1:0] n_o,
  output logic [A_W-1:0]   a_o,
  output logic [CNT_W-1:0] r_q
);
  logic [BANKS-1:0][CNT_W-1:0] bank_n;
  logic [BANKS-1:0][A_W-1:0]   bank_a;
  logic [BSEL_W-1:0]           sel;

  assign sel = ctl_q[SEL_BIT +: BSEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      r_q   <= '0;
    end else if (wr_vld) begin
      unique case (fmt_e'(wr_fmt))
        FMT_SHORT: ctl_q[LO_W-2:0] <= wr_pay[LO_W-2:0];
        FMT_LONG:  ctl_q <= wr_pay[CTL_W-1:0];
        FMT_REF:   r_q <= wr_pay[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_n[b] <= '0;
        bank_a[b] <= '0;
      end else if (wr_vld && wr_fmt == FMT_AN && sel == BSEL_W'(b)) begin
        bank_n[b] <= wr_pay[CNT_W-1:0];
        bank_a[b] <= wr_pay[PAY_W-1:CNT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_o <= '0;
      a_o <= '0;
    end else begin
      n_o <= bank_n[sel];
      a_o <= bank_a[sel];
    end
  end

  // R7: bank contents change only through an N/A word
  a_r7_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_vld && wr_fmt == FMT_AN) |=> ($stable(bank_n) && $stable(bank_a)));

  // R4: the IF reference value changes only through an R word
  a_r4_ref_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_vld && wr_fmt == FMT_REF) |=> $stable(r_q));
endmodule

// File: rtl/syn_serial_ctl.sv
module syn_serial_ctl
  import syn_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CTL_W       = 14,
  parameter int LO_W        = 4,
  parameter int CNT_W       = 14,
  parameter int RF_A_W      = 6,
  parameter int IF_A_W      = 4,
  localparam int RF_PAY_W   = CNT_W + RF_A_W,
  localparam int IF_PAY_W   = CNT_W + IF_A_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sclk,
  input  logic              bus_sdat,
  input  logic              bus_en_n,
  input  logic              rf_reload,
  output logic [CTL_W-1:0]  rf_ctl,
  output logic [CNT_W-1:0]  rf_n,
  output logic [RF_A_W-1:0] rf_a,
  output logic [CNT_W-1:0]  rf_r,
  output logic [CTL_W-1:0]  if_ctl,
  output logic [CNT_W-1:0]  if_n,
  output logic [IF_A_W-1:0] if_a,
  output logic [CNT_W-1:0]  if_r
);
  logic                wr_vld;
  logic [ADDR_W-1:0]   wr_addr;
  logic [RF_PAY_W-1:0] wr_pay;
  logic                rf_wr, if_wr;

  syn_bus_rx #(
    .SYNC_STAGES(SYNC_STAGES), .LO_W(LO_W), .CTL_W(CTL_W),
    .CNT_W(CNT_W), .RF_A_W(RF_A_W), .IF_A_W(IF_A_W)
  ) u_rx (
    .clk(clk), .rst(rst),
    .sclk_i(bus_sclk), .sdat_i(bus_sdat), .en_n_i(bus_en_n),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_pay(wr_pay)
  );

  assign rf_wr = wr_vld & ~wr_addr[0];
  assign if_wr = wr_vld &  wr_addr[0];

  syn_rf_regs #(
    .CTL_W(CTL_W), .LO_W(LO_W), .CNT_W(CNT_W), .A_W(RF_A_W), .SYNC_BIT(CTL_W-1)
  ) u_rf (
    .clk(clk), .rst(rst),
    .wr_vld(rf_wr), .wr_fmt(wr_addr[2:1]), .wr_pay(wr_pay),
    .reload(rf_reload),
    .ctl_q(rf_ctl), .n_q(rf_n), .a_q(rf_a), .r_q(rf_r)
  );

  syn_if_regs #(
    .CTL_W(CTL_W), .LO_W(LO_W), .CNT_W(CNT_W), .A_W(IF_A_W), .SEL_BIT(3), .BANKS(2)
  ) u_if (
    .clk(clk), .rst(rst),
    .wr_vld(if_wr), .wr_fmt(wr_addr[2:1]), .wr_pay(wr_pay[IF_PAY_W-1:0]),
    .ctl_q(if_ctl), .n_o(if_n), .a_o(if_a), .r_q(if_r)
  );
endmodule

// File: tb/syn_serial_ctl_bench.sv
module syn_serial_ctl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sclk = 1'b0, bus_sdat = 1'b0, bus_en_n = 1'b1, rf_reload = 1'b0;
  logic [13:0] rf_ctl, rf_n, rf_r, if_ctl, if_n, if_r;
  logic [5:0]  rf_a;
  logic [3:0]  if_a;

  always #5 clk = ~clk;

  syn_serial_ctl u_syn_serial_ctl (
    .clk(clk), .rst(rst), .bus_sclk(bus_sclk), .bus_sdat(bus_sdat),
    .bus_en_n(bus_en_n), .rf_reload(rf_reload),
    .rf_ctl(rf_ctl), .rf_n(rf_n), .rf_a(rf_a), .rf_r(rf_r),
    .if_ctl(if_ctl), .if_n(if_n), .if_a(if_a), .if_r(if_r)
  );

  typedef struct {
    logic [13:0] rf_ctl, rf_n, rf_r, if_ctl, if_n, if_r;
    logic [5:0]  rf_a;
    logic [3:0]  if_a;
    string       tag;
  } exp_t;

  exp_t exp_s;
  exp_t q[$];
  int checks = 0, bad = 0;
  bit done = 0;

  task automatic cmp(string tag, string name, logic [31:0] act, logic [31:0] ex);
    checks++;
    if (act !== ex) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, ex);
    end
  endtask

  // monitor: pops expected snapshots and compares once outputs settle
  initial begin
    forever begin
      wait (q.size() > 0);
      repeat (10) @(negedge clk);
      begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "rf_ctl", 32'(rf_ctl), 32'(e.rf_ctl));
        cmp(e.tag, "rf_n",   32'(rf_n),   32'(e.rf_n));
        cmp(e.tag, "rf_a",   32'(rf_a),   32'(e.rf_a));
        cmp(e.tag, "rf_r",   32'(rf_r),   32'(e.rf_r));
        cmp(e.tag, "if_ctl", 32'(if_ctl), 32'(e.if_ctl));
        cmp(e.tag, "if_n",   32'(if_n),   32'(e.if_n));
        cmp(e.tag, "if_a",   32'(if_a),   32'(e.if_a));
        cmp(e.tag, "if_r",   32'(if_r),   32'(e.if_r));
      end
    end
  end

  task automatic expect_now(string tag);
    exp_s.tag = tag;
    q.push_back(exp_s);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // word = {payload, a2, a1, channel}, sent MSB first
  task automatic send(int len, logic [22:0] w);
    @(negedge clk);
    bus_en_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      bus_sdat = w[i];
      repeat (3) @(negedge clk);
      bus_sclk = 1'b1;
      repeat (3) @(negedge clk);
      bus_sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
    bus_en_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_reload();
    @(negedge clk);
    rf_reload = 1'b1;
    @(negedge clk);
    rf_reload = 1'b0;
  endtask

  function automatic logic [22:0] w_short(logic ch, logic [3:0] c);
    return {16'b0, c, 2'b00, ch};
  endfunction
  function automatic logic [22:0] w_long(logic ch, logic [13:0] c);
    return {6'b0, c, 2'b01, ch};
  endfunction
  function automatic logic [22:0] w_an(logic ch, logic [13:0] n, logic [5:0] a);
    return {a, n, 2'b10, ch};
  endfunction
  function automatic logic [22:0] w_ref(logic ch, logic [13:0] r);
    return {6'b0, r, 2'b11, ch};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    exp_s = '{rf_ctl: 14'h0, rf_n: 14'h0, rf_r: 14'h0, if_ctl: 14'h0, if_n: 14'h0,
              if_r: 14'h0, rf_a: 6'h0, if_a: 4'h0, tag: ""};
    repeat (10) @(negedge clk);
    rst = 1'b0;
    expect_now("R1 reset");

    // direct-mode RF writes
    send(17, w_ref(1'b0, 14'h1ABC));
    exp_s.rf_r = 14'h1ABC;
    expect_now("R4 rf ref");
    send(23, w_an(1'b0, 14'h0321, 6'h25));
    exp_s.rf_n = 14'h0321; exp_s.rf_a = 6'h25;
    expect_now("R4 rf n/a");
    send(7, w_short(1'b0, 4'hB));
    exp_s.rf_ctl = 14'h000B;
    expect_now("R3 rf short");

    // IF channel and banks
    send(17, w_long(1'b1, 14'h0A05));
    exp_s.if_ctl = 14'h0A05;
    expect_now("R3 if long");
    send(21, w_an(1'b1, 14'h0777, 6'h09));
    exp_s.if_n = 14'h0777; exp_s.if_a = 4'h9;
    expect_now("R7 if bank0 write");
    send(17, w_ref(1'b1, 14'h2222));
    exp_s.if_r = 14'h2222;
    expect_now("R3 if ref");
    send(17, w_long(1'b1, 14'h0A0D));
    exp_s.if_ctl = 14'h0A0D; exp_s.if_n = 14'h0; exp_s.if_a = 4'h0;
    expect_now("R7 select bank1");
    send(21, w_an(1'b1, 14'h0111, 6'h03));
    exp_s.if_n = 14'h0111; exp_s.if_a = 4'h3;
    expect_now("R7 if bank1 write");
    send(7, w_short(1'b1, 4'h7));
    exp_s.if_ctl = 14'h0A0F;
    expect_now("R7 short keeps select");
    send(17, w_long(1'b1, 14'h0A05));
    exp_s.if_ctl = 14'h0A05; exp_s.if_n = 14'h0777; exp_s.if_a = 4'h9;
    expect_now("R7 back to bank0");

    // wrong lengths dropped
    send(16, w_ref(1'b0, 14'h0F0F));
    expect_now("R5 short length");
    send(18, w_ref(1'b0, 14'h0F0F));
    expect_now("R5 long length");
    send(21, w_an(1'b0, 14'h0055, 6'h11));
    expect_now("R5 rf n/a with if length");

    // activity with enable high
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); bus_sdat = i[0];
      repeat (3) @(negedge clk); bus_sclk = 1'b1;
      repeat (3) @(negedge clk); bus_sclk = 1'b0;
    end
    expect_now("R2 enable high ignored");

    // shadowed RF mode
    send(17, w_long(1'b0, 14'h2155));
    exp_s.rf_ctl = 14'h2155;
    expect_now("R6 enter shadow mode");
    send(17, w_ref(1'b0, 14'h0123));
    expect_now("R6 ref shadowed");
    send(23, w_an(1'b0, 14'h0456, 6'h2A));
    expect_now("R6 n/a shadowed");
    send(7, w_short(1'b0, 4'hA));
    expect_now("R8 cp bits shadowed");
    pulse_reload();
    exp_s.rf_r = 14'h0123; exp_s.rf_n = 14'h0456; exp_s.rf_a = 6'h2A;
    expect_now("R6 counters on first strobe");
    pulse_reload();
    exp_s.rf_ctl = 14'h215A;
    expect_now("R8 cp bits on second strobe");
    send(17, w_long(1'b0, 14'h3C93));
    exp_s.rf_ctl = 14'h3C9A;
    expect_now("R9 upper direct in shadow mode");
    pulse_reload();
    expect_now("R8 strobe without armed transfer");
    send(23, w_an(1'b0, 14'h0100, 6'h01));
    expect_now("R6 second n/a shadowed");
    pulse_reload();
    exp_s.rf_n = 14'h0100; exp_s.rf_a = 6'h01;
    expect_now("R8 counters first, cp held");
    pulse_reload();
    exp_s.rf_ctl = 14'h3C93;
    expect_now("R8 cp after counters");

    // leave shadow mode: that word still judged by old c13
    send(17, w_long(1'b0, 14'h1C95));
    exp_s.rf_ctl = 14'h1C93;
    expect_now("R6 mode from prior c13");
    send(7, w_short(1'b0, 4'h6));
    exp_s.rf_ctl = 14'h1C96;
    expect_now("R6 direct short again");
    send(17, w_ref(1'b0, 14'h3FFF));
    exp_s.rf_r = 14'h3FFF;
    expect_now("R6 direct ref again");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule